// File: doc/BRIEF.md
# Black-Level Offset Correction Loop

This block closes a digital feedback loop around a 10-bit pixel converter. It removes the residual offset that is left in the digitized stream. An external window strobe marks the shielded dark pixels at the start of each line. For every pixel clock inside that window, the block takes the converter sample and works out how far it sits from a programmable black target. The target is given in quarter-LSB units. The block adds these errors into a running sum.

When the window closes, the sum is scaled down to a mean by a fixed power-of-two shift. A selectable loop-gain exponent then attenuates the mean, and the result is added to an 8-bit correction register. The register saturates at both ends and drives the code of the offset DAC in front of the converter. A rate field thins the updates to every 2nd, 4th or 8th line. Windows that are too short are discarded. A disable input turns the loop off. While it is set, the target value is passed straight to the DAC as a fixed programmable offset.

The controller is a three-state machine:
- S_IDLE waits for the window.
- S_ACCUM sums errors while the window is high.
- S_APPLY lasts one cycle and commits the correction.

It has these transitions:
- idle_to_accum: the window rises while in S_IDLE.
- accum_hold: the window stays high.
- accum_to_apply: the window falls.
- apply_to_idle: the window is low in S_APPLY.
- apply_to_accum: the window is high again in S_APPLY.
- any_to_idle_on_disable: the loop is disabled.

Top module: `obclamp_loop`

## Requirements
- R1: While rst_n is low, and after it is released until the first update, dac_code is 0 and the controller is in S_IDLE.
- R2: dac_code changes only in two cases. The first is the clock edge one cycle after the edge at which the window is first sampled low (S_APPLY). The second is the edge after loop_dis is sampled high. At the edge that closes the window, dac_code still shows the old value.
- R3: Each sample taken while win is high contributes the signed error target − 4·sample, in quarter-LSB units. The errors of all samples in one window are summed.
- R4: The step is computed in two stages. The first is mean = sum >>> AVG_SHIFT, where AVG_SHIFT is 4 by default. The second is step = mean >>> gain_exp, with gain_exp from 0 to 3. Both shifts are arithmetic and round toward minus infinity.
- R5: The new correction is the old correction plus the step, clamped to the range 0 to 255.
- R6: While loop_dis is high, dac_code equals target one cycle later, and windows neither update it nor count as lines. After loop_dis falls, the loop resumes from that target value.
- R7: Every window end while enabled is one line, numbered from 0 after reset. The update is applied only when the line number modulo 2^rate is 0: rate 0 gives every line, 1 every 2nd, 2 every 4th and 3 every 8th.
- R8: A window with fewer than 4 samples leaves the correction unchanged, but it still counts as a line.
- R9: The divisor is fixed at 2^AVG_SHIFT and does not depend on the window length. An 8-sample window therefore moves the correction half as far as a 16-sample window with the same error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win | input | 1 | Dark-pixel window, high on shielded pixels |
| sample | input | 10 | Converter output sample |
| target | input | 8 | Black target in quarter-LSB units (0 to 63.75 LSB) |
| loop_dis | input | 1 | Loop off; target drives the DAC directly |
| rate | input | 2 | Update every 2^rate lines |
| gain_exp | input | 2 | Loop-gain right-shift exponent |
| dac_code | output | 8 | Offset DAC code |

## Verification
Several properties are checked on every clock by the assertions:
- The correction holds outside the commit cycle and the disable path.
- A disabled loop copies the target.
- No commit follows a window shorter than four samples.
- No commit lands on a line that the rate field skips.
- The first accumulation cycle restarts the count.

The bench scenarios show the behaviour that depends on values: the error arithmetic, the floor rounding of both shifts, saturation at each end, and the fixed divisor on a short window. They also show the line-numbering sequence under a slowed rate, and the resumption from the target after the loop is re-enabled.

// File: rtl/obc_pkg.sv
package obc_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ACCUM = 2'd1,
        S_APPLY = 2'd2
    } obc_state_t;
endpackage

// File: rtl/obc_accum.sv
module obc_accum #(
    parameter int SMP_W = 10,
    parameter int TGT_W = 8,
    parameter int CNT_W = 11,
    parameter int SUM_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    start,
    input  logic                    add,
    input  logic [SMP_W-1:0]        sample,
    input  logic [TGT_W-1:0]        target,
    output logic signed [SUM_W-1:0] sum,
    output logic [CNT_W-1:0]        count
);
    localparam int ERR_W = SMP_W + 3;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic signed [ERR_W-1:0] err;
    logic signed [SUM_W-1:0] err_x;

    // target minus four times the sample, both in quarter-LSB units
    assign err   = $signed({{(ERR_W-TGT_W){1'b0}}, target}) - $signed({1'b0, sample, 2'b00});
    assign err_x = {{(SUM_W-ERR_W){err[ERR_W-1]}}, err};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum   <= '0;
            count <= '0;
        end else if (clear) begin
            sum   <= '0;
            count <= '0;
        end else if (start) begin
            sum   <= err_x;
            count <= CNT_W'(1);
        end else if (add) begin
            sum   <= sum + err_x;
            count <= (count == CNT_MAX) ? count : count + 1'b1;
        end
    end

    a_r3_start_resets_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clear) |=> (count == CNT_W'(1)));
endmodule

// File: rtl/obc_gate.sv
module obc_gate #(
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic [RATE_W-1:0] rate,
    output logic              eligible,
    output logic [(1<<RATE_W)-2:0] line_idx
);
    localparam int LINE_W = (1 << RATE_W) - 1;

    logic [LINE_W-1:0] mask;

    always_comb begin
        mask = '0;
        for (int b = 0; b < LINE_W; b++) begin
            if (b < int'(rate)) mask[b] = 1'b1;
        end
    end

    assign eligible = ((line_idx & mask) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        line_idx <= '0;
        else if (line_end) line_idx <= line_idx + 1'b1;
    end
endmodule

// File: rtl/obc_step.sv
module obc_step #(
    parameter int SUM_W     = 24,
    parameter int AVG_SHIFT = 4,
    parameter int GAIN_W    = 2,
    parameter int DAC_W     = 8
) (
    input  logic signed [SUM_W-1:0] sum,
    input  logic [GAIN_W-1:0]       gain_exp,
    input  logic [DAC_W-1:0]        cur,
    output logic [DAC_W-1:0]        nxt
);
    localparam int W = SUM_W + 1;
    localparam logic signed [W-1:0] TOP = W'((1 << DAC_W) - 1);

    logic signed [SUM_W-1:0] mean;
    logic signed [SUM_W-1:0] step;
    logic signed [W-1:0]     wide;

    always_comb begin
        mean = sum >>> AVG_SHIFT;
        step = mean >>> gain_exp;
        wide = $signed({{(W-DAC_W){1'b0}}, cur}) + $signed({step[SUM_W-1], step});
        if (wide < 0)        nxt = '0;
        else if (wide > TOP) nxt = '1;
        else                 nxt = wide[DAC_W-1:0];
    end
endmodule

// File: rtl/obclamp_loop.sv
module obclamp_loop
    import obc_pkg::*;
#(
    parameter int SMP_W     = 10,
    parameter int DAC_W     = 8,
    parameter int RATE_W    = 2,
    parameter int GAIN_W    = 2,
    parameter int AVG_SHIFT = 4,
    parameter int MAX_WIN   = 1024,
    parameter int MIN_WIN   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win,
    input  logic [SMP_W-1:0]  sample,
    input  logic [DAC_W-1:0]  target,
    input  logic              loop_dis,
    input  logic [RATE_W-1:0] rate,
    input  logic [GAIN_W-1:0] gain_exp,
    output logic [DAC_W-1:0]  dac_code
);
    localparam int CNT_W  = $clog2(MAX_WIN + 1);
    localparam int SUM_W  = SMP_W + 3 + CNT_W;
    localparam int LINE_W = (1 << RATE_W) - 1;

    obc_state_t state, state_nx;
    logic signed [SUM_W-1:0] sum;
    logic [CNT_W-1:0]        count;
    logic [DAC_W-1:0]        corr_nx;
    logic [LINE_W-1:0]       line_idx;
    logic start, add, line_end, eligible, apply;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (loop_dis) begin
            state_nx = S_IDLE;                       // any_to_idle_on_disable
        end else begin
            unique case (state)
                S_IDLE:  if (win) state_nx = S_ACCUM; // idle_to_accum
                S_ACCUM: state_nx = win ? S_ACCUM : S_APPLY; // accum_hold / accum_to_apply
                S_APPLY: state_nx = win ? S_ACCUM : S_IDLE;  // apply_to_accum / apply_to_idle
                default: state_nx = S_IDLE;
            endcase
        end
    end

    always_comb begin
        start    = !loop_dis && win && (state != S_ACCUM);
        add      = !loop_dis && win && (state == S_ACCUM);
        line_end = !loop_dis && (state == S_APPLY);
        apply    = line_end && eligible && (count >= CNT_W'(MIN_WIN));
    end

    obc_accum #(.SMP_W(SMP_W), .TGT_W(DAC_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .clear(loop_dis), .start(start), .add(add),
        .sample(sample), .target(target), .sum(sum), .count(count)
    );

    obc_gate #(.RATE_W(RATE_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .rate(rate),
        .eligible(eligible), .line_idx(line_idx)
    );

    obc_step #(.SUM_W(SUM_W), .AVG_SHIFT(AVG_SHIFT), .GAIN_W(GAIN_W), .DAC_W(DAC_W)) u_step (
        .sum(sum), .gain_exp(gain_exp), .cur(dac_code), .nxt(corr_nx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        dac_code <= '0;
        else if (loop_dis) dac_code <= target;
        else if (apply)    dac_code <= corr_nx;
    end

    a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_dis && !apply) |=> $stable(dac_code));
    a_r6_disable_copies: assert property (@(posedge clk) disable iff (!rst_n)
        loop_dis |=> (dac_code == $past(target)));
    a_r8_min_window: assert property (@(posedge clk) disable iff (!rst_n)
        apply |-> (count >= CNT_W'(MIN_WIN)));
    a_r7_rate_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && rate == 2'd1) |-> (line_idx[0] == 1'b0));
    a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        loop_dis |=> (state == S_IDLE));
endmodule

// File: tb/test_obclamp_loop.sv
module test_obclamp_loop;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       win = 1'b0;
    logic [9:0] sample = '0;
    logic [7:0] target = '0;
    logic       loop_dis = 1'b0;
    logic [1:0] rate = '0;
    logic [1:0] gain_exp = '0;
    logic [7:0] dac_code;

    int n_chk = 0;
    int n_bad = 0;
    int m_corr = 0;
    int m_line = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    obclamp_loop i_obclamp_loop (
        .clk(clk), .rst_n(rst_n), .win(win), .sample(sample), .target(target),
        .loop_dis(loop_dis), .rate(rate), .gain_exp(gain_exp), .dac_code(dac_code)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: dac_code actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one enabled window and check both the hold edge and the commit edge
    task automatic run_line(string req, int n, int smp);
        int sum, step, old;
        old = m_corr;
        for (int i = 0; i < n; i++) begin
            win = 1'b1; sample = 10'(smp);
            @(negedge clk);
        end
        win = 1'b0;
        sum = n * (int'(target) - 4 * smp);
        step = (sum >>> 4) >>> gain_exp;
        if (n >= 4 && (m_line % (1 << rate)) == 0) begin
            m_corr = m_corr + step;
            if (m_corr < 0) m_corr = 0;
            if (m_corr > 255) m_corr = 255;
        end
        m_line++;
        @(negedge clk);
        chk("R2", int'(dac_code), old);
        @(negedge clk);
        chk(req, int'(dac_code), m_corr);
    endtask

    task automatic t_reset;
        chk("R1", int'(dac_code), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R1", int'(dac_code), 0);
    endtask

    task automatic t_basic;
        target = 8'd64; rate = 2'd0; gain_exp = 2'd0;
        run_line("R3", 16, 10);            // +24
    endtask

    task automatic t_gain;
        gain_exp = 2'd2;
        run_line("R4", 16, 10);            // +6
        gain_exp = 2'd3; target = 8'd0;
        run_line("R4", 16, 1);             // mean -4, >>>3 floors to -1
    endtask

    task automatic t_sat;
        gain_exp = 2'd0; target = 8'd64;
        run_line("R5", 16, 100);           // large negative, clamps at 0
        target = 8'd255;
        run_line("R5", 16, 0);             // +255
        run_line("R5", 16, 0);             // clamps at 255
    endtask

    task automatic t_short;
        target = 8'd0;
        run_line("R8", 3, 50);             // ignored, still a line
        run_line("R8", 4, 50);             // four samples do commit
    endtask

    task automatic t_half;
        target = 8'd255;
        run_line("R9", 8, 10);             // half of a 16-sample step
    endtask

    task automatic t_rate;
        target = 8'd40; gain_exp = 2'd1;
        rate = 2'd1;
        for (int k = 0; k < 4; k++) run_line("R7", 16, 12 + k);
        rate = 2'd2;
        for (int k = 0; k < 4; k++) run_line("R7", 16, 5);
        rate = 2'd0;
    endtask

    task automatic t_disable;
        loop_dis = 1'b1; target = 8'd100;
        @(negedge clk);
        chk("R6", int'(dac_code), 100);
        for (int i = 0; i < 10; i++) begin
            win = 1'b1; sample = 10'd300;
            @(negedge clk);
        end
        win = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R6", int'(dac_code), 100);
        loop_dis = 1'b0; m_corr = 100; gain_exp = 2'd0;
        @(negedge clk);
        run_line("R6", 16, 20);            // resumes from target value
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_gain();
        t_sat();
        t_short();
        t_half();
        t_rate();
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule